// File: doc/BRIEF.md
# Modem Control and Status Unit

This block holds the modem-facing register pair of an asynchronous serial controller. A control register drives two general-purpose outputs that are active low. A status register reports the current state of the active-low ring-indicator and carrier-detect inputs, together with two sticky change flags. The modem inputs are asynchronous, so each one passes through a multi-flop synchroniser before its edges are detected.

Software reaches the block through a small register-select bus. Writes take effect at the clock edge. Reads are combinational. A read of the status register clears its change flags. When the modem-status interrupt is enabled and either change flag is set, a level interrupt request is raised. It stays up until the flags are cleared by a status read or by master reset.

A loop-mode input forces both general-purpose outputs to their inactive level and leaves the control register contents untouched. Master reset is asynchronous and active high.

Top module: `modem_ctl_stat`

## Requirements
- R1: A 1 in control register bit 2 drives `gp1_n` low, and a 1 in bit 3 drives `gp2_n` low. A 0 in either bit leaves its pin high.
- R2: While `mreset` is high, and after it is released, the control register reads 0. Both general-purpose outputs are high, both change flags are clear and `ms_irq` is low.
- R3: While `loop_en` is high, `gp1_n` and `gp2_n` are both high whatever the control bits hold. The control register keeps its value.
- R4: Status bit 6 reads the inverse of the synchronised `ring_n` and status bit 7 reads the inverse of the synchronised `carrier_n`. A pin change shows two clock edges later.
- R5: Status bit 2 sets only when synchronised `ring_n` goes from low to high. A high-to-low change leaves it unchanged.
- R6: Status bit 3 sets on any change of synchronised `carrier_n`.
- R7: A read of the status register (select 1 with `rd_en` high) clears status bits 0 to 3 at the clock edge that ends the read cycle. Status bits 0, 1, 4 and 5 always read 0.
- R8: An edge event that reaches the flags in the same cycle as a status read leaves its flag set for the next read.
- R9: `ms_irq` is high exactly when enable register bit 3 is 1 and status bit 2 or bit 3 is set.
- R10: The control register (select 0) and the enable register (select 2) read back the last value written. Select 3 reads 0. Registers change only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mreset | input | 1 | Master reset, asynchronous, active high |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 enable, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; a status read clears the change flags |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected register, combinational |
| loop_en | input | 1 | Loop mode; forces both general-purpose outputs inactive |
| ring_n | input | 1 | Ring indicator, asynchronous, active low |
| carrier_n | input | 1 | Carrier detect, asynchronous, active low |
| gp1_n | output | 1 | General-purpose output 1, active low |
| gp2_n | output | 1 | General-purpose output 2, active low |
| ms_irq | output | 1 | Modem-status interrupt request, active high |

## Verification
Internal faults show up in a few distinct ways at the ports:
- A wrong synchroniser depth or edge polarity changes the cycle in which status bits 6 and 7 move, and which pin transitions set bits 2 and 3. A status read a few cycles after each pin change exposes it.
- A clear-on-read fault shows on the very next status read, as flags that survive or vanish, and at once on `ms_irq` after the read edge.
- A lost coincident edge shows as a missing flag on the following read.
- A control-register or loop-gating fault shows on `gp1_n`/`gp2_n` one edge after the write or at once on a change of `loop_en`.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_STAT = 2'd1,
      REG_IEN  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_ANY  = 1'b1
   } edge_mode_e;

   localparam int unsigned CTL_GP_LSB  = 2;
   localparam int unsigned ST_RI_EDGE  = 2;
   localparam int unsigned ST_DCD_CHG  = 3;
   localparam int unsigned ST_RI_LVL   = 6;
   localparam int unsigned ST_DCD_LVL  = 7;
   localparam int unsigned IEN_MS_BIT  = 3;
   localparam int unsigned MIN_DATA_W  = 8;

endpackage

// File: rtl/mcs_in_sync.sv
module mcs_in_sync #(
   parameter int unsigned         STAGES = 2,
   parameter mcs_pkg::edge_mode_e MODE   = mcs_pkg::EDGE_ANY
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_n,
   output logic level,
   output logic evt
);
   localparam int unsigned TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("mcs_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe_q;
   logic              last_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pipe_q <= '1;
         last_q <= 1'b1;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], pin_n};
         last_q <= pipe_q[TOP];
      end
   end

   assign level = ~pipe_q[TOP];

   if (MODE == mcs_pkg::EDGE_RISE) begin : g_rise
      assign evt = ~last_q & pipe_q[TOP];
   end else begin : g_any
      assign evt = last_q ^ pipe_q[TOP];
   end

endmodule

// File: rtl/mcs_ctl_reg.sv
module mcs_ctl_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_OUT  = 2,
   parameter int unsigned OUT_LSB = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              loop,
   output logic [DATA_W-1:0] ctl_q,
   output logic [N_OUT-1:0]  gp_n
);
   localparam int unsigned OUT_MSB = OUT_LSB + N_OUT - 1;

   if (OUT_MSB >= DATA_W) begin : g_bad_fit
      $error("mcs_ctl_reg: output bits do not fit in DATA_W");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     ctl_q <= '0;
      else if (wr) ctl_q <= wdata;
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign gp_n[i] = loop | ~ctl_q[OUT_LSB + i];
   end

   AST_CTL_STABLE: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(ctl_q)); // R10

endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              mreset,
   input  logic [1:0]        reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              loop_en,
   input  logic              ring_n,
   input  logic              carrier_n,
   output logic              gp1_n,
   output logic              gp2_n,
   output logic              ms_irq
);
   import mcs_pkg::*;

   localparam int unsigned N_GP = 2;

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("modem_ctl_stat: DATA_W must be at least 8");
   end

   reg_sel_e          sel;
   logic              wr_ctl, wr_ien, rd_stat;
   logic [DATA_W-1:0] ctl_q, ien_q, stat_word;
   logic [N_GP-1:0]   gp_n;
   logic              ri_lvl, dcd_lvl, ri_evt, dcd_evt;
   logic              ri_flag, dcd_flag;

   assign sel     = reg_sel_e'(reg_sel);
   assign wr_ctl  = wr_en && (sel == REG_CTL);
   assign wr_ien  = wr_en && (sel == REG_IEN);
   assign rd_stat = rd_en && (sel == REG_STAT);

   mcs_ctl_reg #(
      .DATA_W (DATA_W),
      .N_OUT  (N_GP),
      .OUT_LSB(CTL_GP_LSB)
   ) i_ctl (
      .clk  (clk),
      .rst  (mreset),
      .wr   (wr_ctl),
      .wdata(wdata),
      .loop (loop_en),
      .ctl_q(ctl_q),
      .gp_n (gp_n)
   );

   assign gp1_n = gp_n[0];
   assign gp2_n = gp_n[1];

   mcs_in_sync #(.STAGES(SYNC_STAGES), .MODE(EDGE_RISE)) i_ring (
      .clk(clk), .rst(mreset), .pin_n(ring_n), .level(ri_lvl), .evt(ri_evt)
   );

   mcs_in_sync #(.STAGES(SYNC_STAGES), .MODE(EDGE_ANY)) i_carrier (
      .clk(clk), .rst(mreset), .pin_n(carrier_n), .level(dcd_lvl), .evt(dcd_evt)
   );

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset)      ien_q <= '0;
      else if (wr_ien) ien_q <= wdata;
   end

   // A new event outranks the clear from a coincident read.
   always_ff @(posedge clk or posedge mreset) begin
      if (mreset) begin
         ri_flag  <= 1'b0;
         dcd_flag <= 1'b0;
      end else begin
         ri_flag  <= (ri_flag  & ~rd_stat) | ri_evt;
         dcd_flag <= (dcd_flag & ~rd_stat) | dcd_evt;
      end
   end

   always_comb begin
      stat_word             = '0;
      stat_word[ST_RI_EDGE] = ri_flag;
      stat_word[ST_DCD_CHG] = dcd_flag;
      stat_word[ST_RI_LVL]  = ri_lvl;
      stat_word[ST_DCD_LVL] = dcd_lvl;
   end

   always_comb begin
      case (sel)
         REG_CTL:  rdata = ctl_q;
         REG_STAT: rdata = stat_word;
         REG_IEN:  rdata = ien_q;
         default:  rdata = '0;
      endcase
   end

   assign ms_irq = ien_q[IEN_MS_BIT] & (ri_flag | dcd_flag);

   AST_RI_SETS: assert property (@(posedge clk) disable iff (mreset)
      ri_evt |=> ri_flag); // R5
   AST_DCD_SETS: assert property (@(posedge clk) disable iff (mreset)
      dcd_evt |=> dcd_flag); // R6
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (mreset)
      (rd_stat && !ri_evt && !dcd_evt) |=> (!ri_flag && !dcd_flag)); // R7
   AST_KEEP_ON_READ: assert property (@(posedge clk) disable iff (mreset)
      (rd_stat && (ri_evt || dcd_evt)) |=> (ri_flag || dcd_flag)); // R8
   AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (mreset)
      (rd_stat && !ri_evt && !dcd_evt) |=> !ms_irq); // R9
   AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (mreset)
      loop_en |-> (gp1_n && gp2_n)); // R3

endmodule

// File: tb/test_modem_ctl_stat.sv
module test_modem_ctl_stat;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int WATCHDOG = 100000;

   logic          clk = 1'b0;
   logic          mreset = 1'b1;
   logic [1:0]    reg_sel = 2'd0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          loop_en = 1'b0;
   logic          ring_n = 1'b1;
   logic          carrier_n = 1'b1;
   logic          gp1_n, gp2_n, ms_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_ctl_stat #(.DATA_W(DW), .SYNC_STAGES(2)) i_modem_ctl_stat (
      .clk(clk), .mreset(mreset), .reg_sel(reg_sel), .wr_en(wr_en),
      .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .loop_en(loop_en),
      .ring_n(ring_n), .carrier_n(carrier_n), .gp1_n(gp1_n),
      .gp2_n(gp2_n), .ms_irq(ms_irq)
   );

   // {ring_n, carrier_n, expected status before the read}
   localparam logic [9:0] VEC [0:7] = '{
      {1'b0, 1'b1, 8'h40},
      {1'b1, 1'b1, 8'h04},
      {1'b1, 1'b0, 8'h88},
      {1'b1, 1'b0, 8'h80},
      {1'b0, 1'b1, 8'h48},
      {1'b1, 1'b0, 8'h8C},
      {1'b1, 1'b0, 8'h80},
      {1'b1, 1'b1, 8'h08}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [DW-1:0] d);
      @(negedge clk);
      reg_sel = sel; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_reg(input logic [1:0] sel, output logic [DW-1:0] d);
      @(negedge clk);
      reg_sel = sel; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog all-R actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      // R2 reset state during reset
      check("R2 gp1_n in reset", gp1_n, 1);
      check("R2 gp2_n in reset", gp2_n, 1);
      check("R2 irq in reset", ms_irq, 0);
      mreset = 1'b0;
      read_reg(2'd0, d); check("R2 ctl after reset", d, 8'h00);
      read_reg(2'd1, d); check("R2 status after reset", d, 8'h00);

      // R9 enable interrupt, R10 readback
      write_reg(2'd2, 8'h08);
      read_reg(2'd2, d); check("R10 enable readback", d, 8'h08);

      // Table walk: R4 R5 R6 R7 R9
      for (int i = 0; i < 8; i++) begin
         logic [7:0] exp;
         @(negedge clk);
         ring_n = VEC[i][9]; carrier_n = VEC[i][8];
         exp = VEC[i][7:0];
         settle();
         check($sformatf("R9 irq before read step %0d", i), ms_irq, (exp & 8'h0C) != 0);
         read_reg(2'd1, d);
         check($sformatf("R4/R5/R6 status step %0d", i), d, exp);
         check($sformatf("R9 irq after read step %0d", i), ms_irq, 0);
         read_reg(2'd1, d);
         check($sformatf("R7 status cleared step %0d", i), d, exp & 8'hC0);
      end

      // R4 latency: level shows two edges after the pin change
      @(negedge clk); carrier_n = 1'b0;
      @(posedge clk); @(negedge clk);
      reg_sel = 2'd1; #1 check("R4 level not yet after one edge", rdata[7], 0);
      @(posedge clk); @(negedge clk);
      #1 check("R4 level after two edges", rdata[7], 1);
      settle(); read_reg(2'd1, d);
      @(negedge clk); carrier_n = 1'b1; settle(); read_reg(2'd1, d);

      // R8 edge coincident with read: ring goes low, then rises
      @(negedge clk); ring_n = 1'b0; settle(); read_reg(2'd1, d);
      @(negedge clk); ring_n = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); reg_sel = 2'd1; rd_en = 1'b1;
      #1 d = rdata;
      check("R8 flag not yet visible", d, 8'h00);
      @(negedge clk); rd_en = 1'b0;
      read_reg(2'd1, d); check("R8 flag kept across read", d, 8'h04);

      // R9 masked: flag set but enable bit clear
      write_reg(2'd2, 8'h00);
      @(negedge clk); carrier_n = 1'b0; settle();
      check("R9 irq masked", ms_irq, 0);
      write_reg(2'd2, 8'h08);
      check("R9 irq on enable", ms_irq, 1);
      read_reg(2'd1, d); check("R6 flag under mask", d, 8'h88);

      // R1 control outputs
      write_reg(2'd0, 8'h04);
      check("R1 gp1_n active", gp1_n, 0); check("R1 gp2_n idle", gp2_n, 1);
      write_reg(2'd0, 8'h08);
      check("R1 gp1_n idle", gp1_n, 1); check("R1 gp2_n active", gp2_n, 0);
      write_reg(2'd0, 8'h0C);
      check("R1 both active", {gp1_n, gp2_n}, 2'b00);
      read_reg(2'd0, d); check("R10 ctl readback", d, 8'h0C);
      read_reg(2'd3, d); check("R10 unused select", d, 8'h00);

      // R3 loop mode
      @(negedge clk); loop_en = 1'b1; #1;
      check("R3 loop forces inactive", {gp1_n, gp2_n}, 2'b11);
      read_reg(2'd0, d); check("R3 ctl kept in loop", d, 8'h0C);
      @(negedge clk); loop_en = 1'b0; #1;
      check("R3 outputs return", {gp1_n, gp2_n}, 2'b00);

      // R2 master reset mid-run with flag pending
      @(negedge clk); carrier_n = 1'b1; settle();
      check("R2 pending irq", ms_irq, 1);
      @(negedge clk); mreset = 1'b1;
      @(negedge clk); @(negedge clk); mreset = 1'b0;
      check("R2 outputs high", {gp1_n, gp2_n}, 2'b11);
      check("R2 irq low", ms_irq, 0);
      read_reg(2'd0, d); check("R2 ctl cleared", d, 8'h00);
      read_reg(2'd1, d); check("R2 flags cleared", d, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule